// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the register front end of one DMA channel. A host reaches it through a simple register bus. Each access is a single 32-bit cycle, carries an 8-bit byte offset inside the channel's 256-byte window, and gets its response in the same cycle. The block does three things:

- It keeps the channel's control/status word, the address of the control block to fetch next, and a scratch debug word.
- It shows the six fields of the descriptor that the engine last fetched as read-only words.
- It turns host writes into one-cycle strobes for the engine: a start strobe and a channel-reset strobe. It also sends a strobe that tells a global interrupt collector to drop this channel's bit.

The engine datapath sits beside the block and feeds it back in three ways. It loads descriptor fields one word at a time. It reports a finished control block, so the block latches the end flag, the interrupt flag when enabled, and the next control-block address. It reports that the chain has stopped, so the block clears the active flag and sets the paused flag. The channel interrupt line follows the stored interrupt flag.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every mapped word reads zero, `irq` is low, and `engStart`, `engReset` and `intClr` are low.
- R2: A write to offset 0x04 sets the control-block address, which reads back at 0x04 and drives `startAddr`. Offset 0x20 is a plain read/write debug word.
- R3: Descriptor slot k (k = 0..5) reads at offset 0x08 + 4k. It holds the last `engLoadData` loaded with `engLoadSel` = k. Host writes to 0x08..0x1C are ignored. Slot 0 bit 0 is the interrupt enable, and slot 5 is the next control-block address.
- R4: A write to an offset that is misaligned or above 0x20 changes no state. A read of such an offset returns zero.
- R5: In a status write (offset 0x00), only the bits set in mask 0x30FF0001 take the written value, and all other bits keep their value. Bits 31 and 30 always read as zero, so a write of bit 30 has no effect.
- R6: A status write with bit 1 set clears the end flag. A status write with bit 2 set clears the interrupt flag (bit 2), drops `irq` on the next cycle, and pulses `intClr` for one cycle.
- R7: A status write with bit 31 set clears the status word, the control-block address, all descriptor slots and the debug word. The rest of the same write still applies, and `engReset` pulses for one cycle.
- R8: A status write that takes the active bit (bit 0) from 0 to 1 pulses `engStart` for exactly one cycle, starting on the cycle after the write. In that cycle `startAddr` equals the control-block address, and the paused flag (bit 4) is cleared. A write of 1 while the bit is already 1 does not pulse `engStart`.
- R9: `engDone` sets the end flag (bit 1) and loads the control-block address from descriptor slot 5. When slot 0 bit 0 is set, `engDone` also sets the interrupt flag and `irq`.
- R10: `engStop` clears the active bit and sets the paused bit.
- R11: Engine events win over a host write in the same cycle. `engDone` keeps the end and interrupt flags set against a clearing write, and `engStop` keeps the active bit low and suppresses the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset in the channel window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle; zero when not reading |
| engLoad | input | 1 | Engine loads one descriptor slot |
| engLoadSel | input | 3 | Descriptor slot index |
| engLoadData | input | 32 | Descriptor slot value |
| engDone | input | 1 | Current control block finished |
| engStop | input | 1 | Chain stopped, channel goes idle |
| engStart | output | 1 | One-cycle start strobe for the engine |
| engReset | output | 1 | One-cycle channel reset strobe |
| startAddr | output | 32 | Control-block address for the engine |
| irq | output | 1 | Channel interrupt, level |
| intClr | output | 1 | One-cycle strobe that clears the global status bit |

## Verification
The assertions assume that every input is a defined value on every clock edge, that a bus read and a bus write never happen in the same cycle, and that `engLoadSel` stays below six. They also assume that `engStop` is raised only by the engine, so a start that coincides with it is legitimately suppressed.

The bench drives all inputs on the falling edge from tasks. It draws offsets only from the 8-bit window and descriptor indices only from 0..5. It issues one bus operation per cycle. Engine events and status writes collide only in the directed cases that target R11.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  // Byte offsets inside the channel window
  localparam logic [7:0] OFF_CS  = 8'h00;
  localparam logic [7:0] OFF_CBA = 8'h04;
  localparam logic [7:0] OFF_DBG = 8'h20;
  localparam int unsigned DESC_FIRST_SLOT = 2; // word slot of offset 0x08

  // Status word bit positions
  localparam int unsigned BIT_ACTIVE = 0;
  localparam int unsigned BIT_END    = 1;
  localparam int unsigned BIT_INT    = 2;
  localparam int unsigned BIT_PAUSED = 4;
  localparam int unsigned BIT_RESET  = 31;

  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic wrCbAddr;
    logic wrDebug;
    logic chanRst;
    logic rdEn;
  } csrStrobe_t;

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] RW_MASK = 32'h30FF_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              engDone,
  input  logic              engStop,
  input  logic              infoIntEn,
  output csrStrobe_t        strobe,
  output logic [DATA_W-1:0] csVal,
  output logic              engStart,
  output logic              engReset,
  output logic              intClr,
  output logic              irq
);

  logic [DATA_W-1:0] csQ, csN;
  logic wrCs;
  logic startN, intClrN;

  // Address decode into strobes
  always_comb begin
    wrCs            = busValid && busWrite && (busAddr == OFF_CS);
    strobe.wrCbAddr = busValid && busWrite && (busAddr == OFF_CBA);
    strobe.wrDebug  = busValid && busWrite && (busAddr == OFF_DBG);
    strobe.chanRst  = wrCs && busWdata[BIT_RESET];
    strobe.rdEn     = busValid && !busWrite;
  end

  // Next status word: reset, then write-one-clears, then masked replace,
  // then engine set events which override anything the host wrote.
  always_comb begin
    csN    = csQ;
    startN = 1'b0;
    if (wrCs) begin
      if (busWdata[BIT_RESET]) csN = '0;
      if (busWdata[BIT_END])   csN[BIT_END] = 1'b0;
      if (busWdata[BIT_INT])   csN[BIT_INT] = 1'b0;
      csN = (csN & ~RW_MASK) | (busWdata & RW_MASK);
      startN = !csQ[BIT_ACTIVE] && busWdata[BIT_ACTIVE] && !engStop;
      if (startN) csN[BIT_PAUSED] = 1'b0;
    end
    if (engDone) begin
      csN[BIT_END] = 1'b1;
      if (infoIntEn) csN[BIT_INT] = 1'b1;
    end
    if (engStop) begin
      csN[BIT_ACTIVE] = 1'b0;
      csN[BIT_PAUSED] = 1'b1;
    end
    intClrN = wrCs && (busWdata[BIT_INT] || busWdata[BIT_RESET]) && !csN[BIT_INT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ      <= '0;
      engStart <= 1'b0;
      engReset <= 1'b0;
      intClr   <= 1'b0;
    end else begin
      csQ      <= csN;
      engStart <= startN;
      engReset <= strobe.chanRst;
      intClr   <= intClrN;
    end
  end

  assign csVal = csQ;
  assign irq   = csQ[BIT_INT];

endmodule

// File: rtl/dma_csr_dpath.sv
module dma_csr_dpath
  import dma_csr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_DESC = 6,
  parameter int unsigned SEL_W    = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [7:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              engLoad,
  input  logic [SEL_W-1:0]  engLoadSel,
  input  logic [DATA_W-1:0] engLoadData,
  input  logic              engDone,
  input  logic [DATA_W-1:0] csVal,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] startAddr,
  output logic              infoIntEn
);

  localparam int unsigned NEXT_IDX  = NUM_DESC - 1;
  localparam int unsigned SLOT_LAST = DESC_FIRST_SLOT + NUM_DESC - 1;

  logic [DATA_W-1:0] descQ [NUM_DESC];
  logic [DATA_W-1:0] cbAddrQ;
  logic [DATA_W-1:0] debugQ;
  logic [5:0]        slot;
  logic              descHit;

  // Descriptor slots: an engine load wins over a channel reset
  for (genvar g = 0; g < NUM_DESC; g++) begin : gDesc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        descQ[g] <= '0;
      end else if (engLoad && (engLoadSel == SEL_W'(g))) begin
        descQ[g] <= engLoadData;
      end else if (strobe.chanRst) begin
        descQ[g] <= '0;
      end
    end
  end

  // Control-block address: chaining from the engine wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cbAddrQ <= '0;
    end else if (engDone) begin
      cbAddrQ <= descQ[NEXT_IDX];
    end else if (strobe.chanRst) begin
      cbAddrQ <= '0;
    end else if (strobe.wrCbAddr) begin
      cbAddrQ <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      debugQ <= '0;
    end else if (strobe.chanRst) begin
      debugQ <= '0;
    end else if (strobe.wrDebug) begin
      debugQ <= busWdata;
    end
  end

  // Read mux
  always_comb begin
    slot    = busAddr[7:2];
    descHit = (busAddr[1:0] == 2'b00) &&
              (slot >= 6'(DESC_FIRST_SLOT)) && (slot <= 6'(SLOT_LAST));
    busRdata = '0;
    if (strobe.rdEn) begin
      if (busAddr == OFF_CS) begin
        busRdata = csVal;
        busRdata[BIT_RESET] = 1'b0;
      end else if (busAddr == OFF_CBA) begin
        busRdata = cbAddrQ;
      end else if (busAddr == OFF_DBG) begin
        busRdata = debugQ;
      end else if (descHit) begin
        for (int k = 0; k < NUM_DESC; k++) begin
          if (slot == 6'(DESC_FIRST_SLOT + k)) busRdata = descQ[k];
        end
      end
    end
  end

  assign startAddr = cbAddrQ;
  assign infoIntEn = descQ[0][0];

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_DESC = 6,
  parameter logic [DATA_W-1:0] RW_MASK = 32'h30FF_0001,
  localparam int unsigned SEL_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              engLoad,
  input  logic [SEL_W-1:0]  engLoadSel,
  input  logic [DATA_W-1:0] engLoadData,
  input  logic              engDone,
  input  logic              engStop,
  output logic              engStart,
  output logic              engReset,
  output logic [DATA_W-1:0] startAddr,
  output logic              irq,
  output logic              intClr
);

  csrStrobe_t        strobe;
  logic [DATA_W-1:0] csVal;
  logic              infoIntEn;

  dma_csr_ctrl #(.DATA_W(DATA_W), .RW_MASK(RW_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .engDone(engDone),
    .engStop(engStop), .infoIntEn(infoIntEn), .strobe(strobe),
    .csVal(csVal), .engStart(engStart), .engReset(engReset),
    .intClr(intClr), .irq(irq)
  );

  dma_csr_dpath #(.DATA_W(DATA_W), .NUM_DESC(NUM_DESC)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .engLoad(engLoad), .engLoadSel(engLoadSel),
    .engLoadData(engLoadData), .engDone(engDone), .csVal(csVal),
    .busRdata(busRdata), .startAddr(startAddr), .infoIntEn(infoIntEn)
  );

endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [7:0]  busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic        engStop,
  input logic        engDone,
  input logic        engStart,
  input logic        engReset,
  input logic        irq,
  input logic        intClr
);

  logic statusWr;
  assign statusWr = busValid && busWrite && (busAddr == 8'h00);

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  assert_start_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> $past(statusWr && busWdata[0] && !engStop));

  assert_reset_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    engReset |-> $past(statusWr && busWdata[31]));

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(engDone));

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(statusWr && (busWdata[2] || busWdata[31])));

  assert_intclr_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    intClr |-> !irq);

  assert_top_bits_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == 8'h00) |-> (busRdata[31:30] == 2'b00));

  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && (busAddr[1:0] != 2'b00 || busAddr > 8'h20))
      |-> (busRdata == 32'h0));

endmodule

bind dma_chan_csr dma_chan_csr_chk u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .engStop(engStop), .engDone(engDone), .engStart(engStart),
  .engReset(engReset), .irq(irq), .intClr(intClr)
);

// File: tb/sim_dma_chan_csr.sv
module sim_dma_chan_csr;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h30FF_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engLoad = 1'b0;
  logic [2:0]  engLoadSel = '0;
  logic [31:0] engLoadData = '0;
  logic        engDone = 1'b0, engStop = 1'b0;
  logic        engStart, engReset, irq, intClr;
  logic [31:0] startAddr;

  int errs = 0;
  int nChk = 0;

  // Reference state
  logic [31:0] mCs = '0, mCb = '0, mDbg = '0;
  logic [31:0] mDesc [6];
  bit expStart, expRst, expClr;
  logic obsStart, obsRst, obsClr;
  logic [31:0] obsAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_csr u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .engLoad(engLoad), .engLoadSel(engLoadSel), .engLoadData(engLoadData),
    .engDone(engDone), .engStop(engStop), .engStart(engStart),
    .engReset(engReset), .startAddr(startAddr), .irq(irq), .intClr(intClr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a);
    logic [5:0] s;
    s = a[7:2];
    if (a == 8'h00) return mCs;
    if (a == 8'h04) return mCb;
    if (a == 8'h20) return mDbg;
    if (a[1:0] == 2'b00 && s >= 6'd2 && s <= 6'd7) return mDesc[s - 6'd2];
    return 32'h0;
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    if (a == 8'h00) return "R5";
    if (a == 8'h04 || a == 8'h20) return "R2";
    if (a[1:0] == 2'b00 && a >= 8'h08 && a <= 8'h1C) return "R3";
    return "R4";
  endfunction

  // Reference update for one cycle, following the requirement priorities
  task automatic modelCycle(input bit wr, input logic [7:0] a, input logic [31:0] d,
                            input bit ld, input logic [2:0] sel, input logic [31:0] ldat,
                            input bit done, input bit stop);
    logic [31:0] c, preInfo, preNext;
    preInfo = mDesc[0];
    preNext = mDesc[5];
    expStart = 0; expRst = 0; expClr = 0;
    if (wr && a == 8'h00) begin
      c = mCs;
      if (d[31]) begin
        c = '0; mCb = '0; mDbg = '0; expRst = 1;
        for (int k = 0; k < 6; k++) mDesc[k] = '0;
      end
      if (d[1]) c[1] = 1'b0;
      if (d[2]) c[2] = 1'b0;
      c = (c & ~MASK) | (d & MASK);
      expStart = !mCs[0] && d[0] && !stop;
      if (expStart) c[4] = 1'b0;
      mCs = c;
    end
    if (wr && a == 8'h04 && !done) mCb = d;
    if (wr && a == 8'h20) mDbg = d;
    if (ld) mDesc[sel] = ldat;
    if (done) begin
      mCs[1] = 1'b1;
      if (preInfo[0]) mCs[2] = 1'b1;
      mCb = preNext;
    end
    if (stop) begin
      mCs[0] = 1'b0;
      mCs[4] = 1'b1;
    end
    expClr = wr && a == 8'h00 && (d[2] || d[31]) && !mCs[2];
  endtask

  task automatic cycleOp(input bit wr, input logic [7:0] a, input logic [31:0] d,
                         input bit ld, input logic [2:0] sel, input logic [31:0] ldat,
                         input bit done, input bit stop);
    @(negedge clk);
    busValid = wr; busWrite = wr; busAddr = a; busWdata = d;
    engLoad = ld; engLoadSel = sel; engLoadData = ldat;
    engDone = done; engStop = stop;
    @(negedge clk);
    busValid = 0; busWrite = 0; engLoad = 0; engDone = 0; engStop = 0;
    obsStart = engStart; obsRst = engReset; obsClr = intClr; obsAddr = startAddr;
    modelCycle(wr, a, d, ld, sel, ldat, done, stop);
    chk(obsStart == expStart, "R8 engStart", 32'(obsStart), 32'(expStart));
    if (expStart) chk(obsAddr == mCb, "R8 startAddr", obsAddr, mCb);
    chk(obsRst == expRst, "R7 engReset", 32'(obsRst), 32'(expRst));
    chk(obsClr == expClr, "R6 intClr", 32'(obsClr), 32'(expClr));
    chk(irq == mCs[2], "R9 irq level", 32'(irq), 32'(mCs[2]));
  endtask

  task automatic doRead(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    #1;
    e = expRead(a);
    chk(busRdata == e, tag, busRdata, e);
    busValid = 0;
  endtask

  task automatic readAll(input string tag);
    for (int k = 0; k <= 8; k++) doRead(8'(k * 4), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; nChk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, nChk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) mDesc[k] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    readAll("R1 reset read");
    chk(irq == 0 && engStart == 0 && engReset == 0 && intClr == 0,
        "R1 outputs", {28'h0, irq, engStart, engReset, intClr}, 32'h0);

    // R2: address and debug words
    cycleOp(1, 8'h04, 32'h1000_0040, 0, 0, 0, 0, 0);
    doRead(8'h04, "R2 cb address");
    chk(startAddr == 32'h1000_0040, "R2 startAddr", startAddr, 32'h1000_0040);
    cycleOp(1, 8'h20, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
    doRead(8'h20, "R2 debug");

    // R3: descriptor loads, host writes ignored
    for (int k = 0; k < 6; k++)
      cycleOp(0, 0, 0, 1, 3'(k), 32'hA000_0000 + 32'(k * 16), 0, 0);
    cycleOp(0, 0, 0, 1, 3'd0, 32'h0000_0001, 0, 0);
    cycleOp(1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    cycleOp(1, 8'h1C, 32'h1234_5678, 0, 0, 0, 0, 0);
    readAll("R3 descriptor");

    // R4: unmapped writes and reads
    cycleOp(1, 8'h24, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    cycleOp(1, 8'h05, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    doRead(8'h24, "R4 unmapped read");
    doRead(8'h06, "R4 misaligned read");
    readAll("R4 state unchanged");

    // R5: masked status write, top bits read zero
    cycleOp(1, 8'h00, 32'hFFFF_FFFE & ~32'h8000_0000, 0, 0, 0, 0, 0);
    doRead(8'h00, "R5 masked write");
    chk(expRead(8'h00) == 32'h30FF_0000, "R5 mask value", expRead(8'h00), 32'h30FF_0000);

    // R8: start edge, single cycle pulse, no restart
    cycleOp(1, 8'h00, 32'h0000_0001, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(engStart == 0, "R8 pulse width", 32'(engStart), 32'h0);
    cycleOp(1, 8'h00, 32'h0000_0001, 0, 0, 0, 0, 0);

    // R9: done with interrupt enable, chaining
    cycleOp(0, 0, 0, 0, 0, 0, 1, 0);
    doRead(8'h04, "R9 chained address");
    doRead(8'h00, "R9 end and int flags");

    // R11: done collides with a clearing write
    cycleOp(1, 8'h00, 32'h0000_0007, 0, 0, 0, 1, 0);
    doRead(8'h00, "R11 flags held");
    chk(irq == 1, "R11 irq held", 32'(irq), 32'h1);

    // R10: stop
    cycleOp(0, 0, 0, 0, 0, 0, 0, 1);
    doRead(8'h00, "R10 stopped");

    // R6: write-one-clear
    cycleOp(1, 8'h00, 32'h0000_0006, 0, 0, 0, 0, 0);
    chk(irq == 0 && obsClr == 1, "R6 irq drop", {30'h0, irq, obsClr}, 32'h1);
    doRead(8'h00, "R6 flags cleared");

    // R11: start suppressed by a simultaneous stop
    cycleOp(1, 8'h00, 32'h0000_0001, 0, 0, 0, 0, 1);
    doRead(8'h00, "R11 stop wins");

    // R7: channel reset
    cycleOp(1, 8'h00, 32'h8000_0000, 0, 0, 0, 0, 0);
    readAll("R7 all cleared");
    @(negedge clk);
    chk(engReset == 0, "R7 pulse width", 32'(engReset), 32'h0);

    // Mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [7:0] a;
      logic [31:0] d;
      kind = int'($urandom % 10);
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(($urandom % 10) * 4);
      d = $urandom;
      if (a == 8'h00 && ($urandom % 6 != 0)) d[31] = 1'b0;
      case (kind)
        0, 1, 2, 3: cycleOp(1, a, d, 0, 0, 0, 0, 0);
        4, 5: cycleOp(0, 0, 0, 1, 3'($urandom % 6), $urandom, 0, 0);
        6: cycleOp(0, 0, 0, 0, 0, 0, 1, 0);
        7: cycleOp(0, 0, 0, 0, 0, 0, 0, 1);
        default: doRead(a, tagOf(a));
      endcase
    end
    readAll("R5 final state");

    $display("Result: errors=%0d of %0d checks", errs, nChk);
    $finish;
  end

endmodule